// File: doc/BRIEF.md
# Bit Count and Scan Unit

This block computes a small integer answer about a 64-bit operand: how many of its bits are set, how many zero bits sit above the highest set bit or below the lowest one, or the position of the lowest or highest set bit. A caller presents an opcode and an operand with a valid strobe. One clock later the unit presents a 7-bit result with a matching valid flag.

All five operations share one datapath. An adder tree produces the population count. A single priority tree, fed either the operand or its bit-reversed image, serves both zero counts and both scans. Both trees are logarithmic in depth. A zero operand has no set bit to locate. The two zero counts then report the full width (64). The two scans raise an undefined flag and force the result to zero.

Top module: `bitcnt_unit`

## Requirements
- R1: Opcode 0 (population count) returns the number of 1 bits in the operand, from 0 to 64.
- R2: Opcode 1 (leading-zero count) returns the number of 0 bits above the most significant 1 bit, and 64 for a zero operand.
- R3: Opcode 2 (trailing-zero count) returns the number of 0 bits below the least significant 1 bit, and 64 for a zero operand.
- R4: Opcode 3 (forward scan) returns the bit index (0 = LSB) of the lowest 1 bit of a nonzero operand.
- R5: Opcode 4 (reverse scan) returns the bit index (0 = LSB) of the highest 1 bit of a nonzero operand.
- R6: The undefined flag is 1 exactly when a scan (opcode 3 or 4) is applied to a zero operand, and the result is then 0. For every other accepted request the flag is 0.
- R7: Opcodes 5, 6 and 7 return a result of 0 with the undefined flag at 0.
- R8: A request sampled with the valid strobe high at a rising edge appears on the result and flag outputs at that edge, with the output valid high for that one cycle.
- R9: In a cycle without the valid strobe, the output valid goes low and the result and flag keep their previous values, whatever the opcode and operand inputs carry.
- R10: While the synchronous active-low reset is low at a rising edge, the output valid, result and flag are cleared to 0, even if the valid strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation select (0..4 defined) |
| in_operand | input | 64 | Operand |
| out_valid | output | 1 | Result valid, one cycle after a request |
| out_result | output | 7 | Count or bit index |
| out_undef | output | 1 | Scan of a zero operand |

## Verification
The bench targets operands where off-by-one and wrong-priority errors show up. These include zero, all ones, a single bit at position 0 or 63, and both end bits set. A tree that merges its halves in the wrong order returns the count from the wrong side on such operands. A missing all-zero override makes the zero counts return 63 instead of 64, or makes a scan report a nonzero index. The bench also sends idle cycles with changed inputs, unused opcodes and a reset asserted alongside the strobe. A register that loads without the strobe changes its result in the idle cycle. A flag decode that leaks into the counts sets the undefined flag on a count operation.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   typedef enum logic [2:0] {
      BCS_POP  = 3'd0,
      BCS_LZC  = 3'd1,
      BCS_TZC  = 3'd2,
      BCS_FWD  = 3'd3,
      BCS_REV  = 3'd4
   } bcs_op_e;
endpackage

// File: rtl/bcs_pop_tree.sv
// Population count as a balanced adder tree: each level halves the node count.
module bcs_pop_tree #(
   parameter int DATA_W = 64,
   localparam int LOG_W = $clog2(DATA_W),
   localparam int RES_W = LOG_W + 1
) (
   input  logic [DATA_W-1:0] vec,
   output logic [RES_W-1:0]  ones
);
   for (genvar l = 0; l <= LOG_W; l++) begin : g_lvl
      localparam int N = DATA_W >> l;
      logic [RES_W-1:0] c [N];
      if (l == 0) begin : g_leaf
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign c[i] = RES_W'(vec[i]);
         end
      end else begin : g_sum
         for (genvar i = 0; i < N; i++) begin : g_node
            assign c[i] = g_lvl[l-1].c[2*i] + g_lvl[l-1].c[2*i+1];
         end
      end
   end

   assign ones = g_lvl[LOG_W].c[0];
endmodule

// File: rtl/bcs_lz_tree.sv
// Leading-zero priority tree. Each node carries an all-zero flag and a count.
// A node takes the upper child's count, or the lower child's count with the
// upper half's width OR-ed in when the upper child is all zero.
module bcs_lz_tree #(
   parameter int DATA_W = 64,
   localparam int LOG_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] vec,
   output logic [LOG_W-1:0]  lz,
   output logic              all_zero
);
   for (genvar l = 0; l <= LOG_W; l++) begin : g_lvl
      localparam int N = DATA_W >> l;
      logic [N-1:0]     z;
      logic [LOG_W-1:0] c [N];
      if (l == 0) begin : g_leaf
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign z[i] = ~vec[i];
            assign c[i] = '0;
         end
      end else begin : g_merge
         localparam logic [LOG_W-1:0] HALF_B = LOG_W'(1) << (l - 1);
         for (genvar i = 0; i < N; i++) begin : g_node
            assign z[i] = g_lvl[l-1].z[2*i+1] & g_lvl[l-1].z[2*i];
            assign c[i] = g_lvl[l-1].z[2*i+1] ? (g_lvl[l-1].c[2*i] | HALF_B)
                                               : g_lvl[l-1].c[2*i+1];
         end
      end
   end

   assign lz       = g_lvl[LOG_W].c[0];
   assign all_zero = g_lvl[LOG_W].z[0];
endmodule

// File: rtl/bitcnt_unit.sv
module bitcnt_unit #(
   parameter int DATA_W = 64,
   localparam int LOG_W = $clog2(DATA_W),
   localparam int RES_W = LOG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_op,
   input  logic [DATA_W-1:0] in_operand,
   output logic              out_valid,
   output logic [RES_W-1:0]  out_result,
   output logic              out_undef
);
   import bcs_pkg::*;

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("bitcnt_unit: DATA_W must be a power of two of at least 2");
   end

   localparam logic [RES_W-1:0] FULL_W = RES_W'(DATA_W);
   localparam logic [RES_W-1:0] TOP_IX = RES_W'(DATA_W - 1);

   logic [DATA_W-1:0] flipped;
   logic [DATA_W-1:0] scan_vec;
   logic              low_side;
   logic [RES_W-1:0]  pop_cnt;
   logic [LOG_W-1:0]  lz_cnt;
   logic              opnd_zero;
   logic [RES_W-1:0]  res_d;
   logic              undef_d;

   for (genvar i = 0; i < DATA_W; i++) begin : g_flip
      assign flipped[i] = in_operand[DATA_W-1-i];
   end

   assign low_side = (in_op == BCS_TZC) || (in_op == BCS_FWD);
   assign scan_vec = low_side ? flipped : in_operand;

   bcs_pop_tree #(.DATA_W(DATA_W)) i_pop (
      .vec  (in_operand),
      .ones (pop_cnt)
   );

   bcs_lz_tree #(.DATA_W(DATA_W)) i_lz (
      .vec      (scan_vec),
      .lz       (lz_cnt),
      .all_zero (opnd_zero)
   );

   always_comb begin
      res_d   = '0;
      undef_d = 1'b0;
      case (in_op)
         BCS_POP: res_d = pop_cnt;
         BCS_LZC,
         BCS_TZC: res_d = opnd_zero ? FULL_W : RES_W'(lz_cnt);
         BCS_FWD: begin
            undef_d = opnd_zero;
            res_d   = opnd_zero ? '0 : RES_W'(lz_cnt);
         end
         BCS_REV: begin
            undef_d = opnd_zero;
            res_d   = opnd_zero ? '0 : TOP_IX - RES_W'(lz_cnt);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_undef  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= res_d;
            out_undef  <= undef_d;
         end
      end
   end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
   parameter int DATA_W = 64,
   localparam int RES_W = $clog2(DATA_W) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        in_op,
   input logic [DATA_W-1:0] in_operand,
   input logic              out_valid,
   input logic [RES_W-1:0]  out_result,
   input logic              out_undef
);
   assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_result) && $stable(out_undef)));

   assert_undef_zero_res_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_undef) |-> (out_result == '0));

   assert_count_no_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op != 3'd3 && in_op != 3'd4) |=> !out_undef);

   assert_scan_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_op == 3'd3 || in_op == 3'd4) && in_operand != '0) |=> !out_undef);

   assert_lzc_zero_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 3'd1 && in_operand == '0) |=> (out_result == RES_W'(DATA_W)));

   assert_pop_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid) |-> (out_result <= RES_W'(DATA_W)));

   assert_unused_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op > 3'd4) |=> (out_result == '0 && !out_undef));
endmodule

bind bitcnt_unit bcs_checker #(.DATA_W(DATA_W)) i_bcs_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_op      (in_op),
   .in_operand (in_operand),
   .out_valid  (out_valid),
   .out_result (out_result),
   .out_undef  (out_undef)
);

// File: tb/test_bitcnt_unit.sv
module test_bitcnt_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = 3'd0;
   logic [63:0] in_operand = '0;
   logic        out_valid;
   logic [6:0]  out_result;
   logic        out_undef;

   int checks = 0;
   int errors = 0;
   logic [6:0] last_res = '0;
   logic       last_undef = 1'b0;

   always #2 clk = ~clk;

   bitcnt_unit i_bitcnt_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_operand(in_operand), .out_valid(out_valid),
      .out_result(out_result), .out_undef(out_undef)
   );

   function automatic logic [6:0] m_pop(logic [63:0] v);
      logic [6:0] n = '0;
      for (int i = 0; i < 64; i++) n += 7'(v[i]);
      return n;
   endfunction

   function automatic logic [6:0] m_lz(logic [63:0] v);
      for (int i = 63; i >= 0; i--) if (v[i]) return 7'(63 - i);
      return 7'd64;
   endfunction

   function automatic logic [6:0] m_tz(logic [63:0] v);
      for (int i = 0; i < 64; i++) if (v[i]) return 7'(i);
      return 7'd64;
   endfunction

   function automatic logic [6:0] m_res(logic [2:0] op, logic [63:0] v);
      case (op)
         3'd0: return m_pop(v);
         3'd1: return m_lz(v);
         3'd2: return m_tz(v);
         3'd3: return (v == 0) ? 7'd0 : m_tz(v);
         3'd4: return (v == 0) ? 7'd0 : 7'(63) - m_lz(v);
         default: return 7'd0;
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] op);
      case (op)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic run_op(logic [2:0] op, logic [63:0] v);
      logic [6:0] er;
      logic       eu;
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_operand = v;
      er = m_res(op, v);
      eu = (op == 3'd3 || op == 3'd4) && v == 0;
      @(posedge clk); #1;
      check("R8 valid", 64'(out_valid), 64'd1);
      check(tag_of(op), 64'(out_result), 64'(er));
      check("R6 undef", 64'(out_undef), 64'(eu));
      last_res = er; last_undef = eu;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      in_valid = 1'b0;
      in_op = 3'($urandom_range(0, 7));
      in_operand = {$urandom, $urandom};
      @(posedge clk); #1;
      check("R9 valid", 64'(out_valid), 64'd0);
      check("R9 result", 64'(out_result), 64'(last_res));
      check("R9 undef", 64'(out_undef), 64'(last_undef));
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [63:0] corners [8];
      void'($urandom(32'd20240611));
      corners[0] = 64'd0;
      corners[1] = '1;
      corners[2] = 64'd1;
      corners[3] = 64'h8000_0000_0000_0000;
      corners[4] = 64'h8000_0000_0000_0001;
      corners[5] = 64'h0000_0001_0000_0000;
      corners[6] = 64'h0000_0000_8000_0000;
      corners[7] = 64'h5555_5555_5555_5555;

      in_valid = 1'b1; in_operand = '1;
      repeat (3) @(posedge clk);
      #1;
      check("R10 valid", 64'(out_valid), 64'd0);
      check("R10 result", 64'(out_result), 64'd0);
      check("R10 undef", 64'(out_undef), 64'd0);
      @(negedge clk); in_valid = 1'b0; rst_n = 1'b1;

      for (int c = 0; c < 8; c++)
         for (int op = 0; op < 8; op++)
            run_op(3'(op), corners[c]);

      idle_cycle();

      for (int k = 0; k < 1500; k++) begin
         logic [63:0] v;
         case ($urandom_range(0, 3))
            0: v = {$urandom, $urandom};
            1: v = 64'd1 << $urandom_range(0, 63);
            2: v = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            default: v = {$urandom, $urandom} >> $urandom_range(0, 63);
         endcase
         run_op(3'($urandom_range(0, 7)), v);
         if ($urandom_range(0, 7) == 0) idle_cycle();
      end

      run_op(3'd4, 64'd0);
      idle_cycle();

      @(negedge clk); rst_n = 1'b0; in_valid = 1'b1; in_op = 3'd0; in_operand = '1;
      @(posedge clk); #1;
      check("R10 mid valid", 64'(out_valid), 64'd0);
      check("R10 mid result", 64'(out_result), 64'd0);
      @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
      @(posedge clk); #1;
      finish_run();
   end
endmodule